// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Width Normalization

This block sits between a register write path and the serial link toward an audio codec. Software writes 32-bit words that carry audio samples of 12, 16, 18 or 20 bits. The block left-justifies each sample into a 20-bit slot and stores it in a circular queue. In compact mode a single word carries two 16-bit halves, and the block unpacks them into two queue entries. The fill level always counts samples, so it does not depend on the packing mode.

A small control register selects the sample width, the packing mode, the enable and the data slots. The queue drains to a codec port that has a valid/ready handshake, moving one stereo pair (older entry as left, next entry as right) per accepted cycle. Draining starts only when the queue is at least half full. Once started, it continues while the codec accepts and a complete pair remains. Four status flags report the state of the queue: empty, half-empty, full and underrun.

Top module: `audtx_fifo`

## Requirements
- R1: A control write (`ctl_we`) registers `ctl_wdata`. Bit 0 enables transmit, bit 1 selects data slot 3, bit 2 selects data slot 4, bits [4:3] give the sample size (0 = 16-bit, 1 = 18-bit, 2 = 20-bit, 3 = 12-bit) and bit 5 requests compact mode. The new setting applies to the writes and drains that follow.
- R2: In non-compact mode each write stores one entry equal to the write word shifted left by 8 (12-bit), 4 (16-bit), 2 (18-bit) or 0 (20-bit), keeping bits [19:0].
- R3: In compact mode each write stores two entries. The first is bits [15:0] of the word and the second is bits [31:16]. Each half is shifted left by 8 for 12-bit samples or by 4 for 16-bit samples, keeping 20 bits.
- R4: A compact request combined with an 18-bit or 20-bit size is ignored, and writes are stored as in non-compact mode.
- R5: `fill_level` counts stored samples, from 0 to DEPTH. A write whose samples do not all fit, judged against the level at the start of the cycle, is dropped whole and the level and stored contents do not change.
- R6: A write that leaves the level above zero clears empty and underrun. A write that leaves the level at or above DEPTH/2 clears half-empty. A write that leaves the level at DEPTH sets full.
- R7: `cdc_valid` rises only when transmit is enabled, slot 3 or slot 4 is selected and the level is at least DEPTH/2. With no slot selected, or with transmit disabled, nothing drains.
- R8: Each cycle with `cdc_valid` and `cdc_ready` high removes one pair. A drain keeps going below DEPTH/2 while at least two samples remain and the codec accepts. A cycle with `cdc_valid` high and `cdc_ready` low ends the drain, and it restarts only when the level reaches DEPTH/2 again.
- R9: Each drained pair clears full and sets half-empty if the level left is at or below DEPTH/2. A level of zero also sets empty and underrun.
- R10: After reset the level is 0, empty and half-empty are 1, full and underrun are 0, and `cdc_valid` is 0.
- R11: `cdc_left` and `cdc_right` always show the oldest and second-oldest stored samples, and they hold while a pair is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control word (enable, slots, size, compact) |
| smp_we | input | 1 | Sample word write strobe |
| smp_wdata | input | 32 | Sample word |
| cdc_ready | input | 1 | Codec accepts a pair this cycle |
| cdc_valid | output | 1 | A pair is offered to the codec |
| cdc_left | output | 20 | Left (older) sample of the offered pair |
| cdc_right | output | 20 | Right (newer) sample of the offered pair |
| fill_level | output | $clog2(DEPTH)+1 | Number of stored samples |
| st_empty | output | 1 | Empty flag |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
Normalization is tried with one word per size code in non-compact mode, each with stray upper bits, so that a wrong shift or a missing mask gives a different stored value. Compact words with distinct halves show whether the halves are swapped. Compact requests at 18 and 20 bits show whether the block falls back correctly. The drain policy is tried with a level just below and exactly at half depth, with an odd level that must leave a single sample behind, with no slot selected, and with a one-cycle refusal in the middle of a drain that must stop it below the threshold. Overflow is tried in both packing modes, including a compact word that would need one slot more than remains.

// File: rtl/audtx_pkg.sv
`timescale 1ns/1ps
package audtx_pkg;

    localparam int SMP_W  = 20;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int CTL_W  = 6;

    // control word field positions
    localparam int CF_EN  = 0;
    localparam int CF_SL3 = 1;
    localparam int CF_SL4 = 2;
    localparam int CF_SZ  = 3;
    localparam int CF_CMP = 5;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ18 = 2'd1,
        SZ20 = 2'd2,
        SZ12 = 2'd3
    } size_e;

    typedef struct packed {
        logic  en;
        logic  slot3;
        logic  slot4;
        size_e size;
        logic  compact;
    } txcfg_t;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
        logic under;
    } txflags_t;

    function automatic logic [SMP_W-1:0] pad_word(size_e sz, logic [WORD_W-1:0] v);
        case (sz)
            SZ12:    return {v[11:0], 8'h00};
            SZ16:    return {v[15:0], 4'h0};
            SZ18:    return {v[17:0], 2'b00};
            default: return v[SMP_W-1:0];
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] pad_half(size_e sz, logic [HALF_W-1:0] h);
        if (sz == SZ12) return {h[11:0], 8'h00};
        return {h, 4'h0};
    endfunction

endpackage

// File: rtl/audtx_ctrl.sv
`timescale 1ns/1ps
module audtx_ctrl
    import audtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output txcfg_t           cfg
);
    size_e  sz_w;
    txcfg_t cfg_n;

    always_comb begin
        sz_w          = size_e'(ctl_wdata[CF_SZ +: 2]);
        cfg_n.en      = ctl_wdata[CF_EN];
        cfg_n.slot3   = ctl_wdata[CF_SL3];
        cfg_n.slot4   = ctl_wdata[CF_SL4];
        cfg_n.size    = sz_w;
        // packing two halves is only legal for the narrow sizes
        cfg_n.compact = ctl_wdata[CF_CMP] && (sz_w == SZ16 || sz_w == SZ12);
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg <= '0;
        else if (ctl_we) cfg <= cfg_n;
    end

    // R4
    compact_size_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.compact |-> (cfg.size == SZ16 || cfg.size == SZ12));

    // R1
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (cfg.size == size_e'($past(ctl_wdata[CF_SZ +: 2]))
                    && cfg.en == $past(ctl_wdata[CF_EN])));

endmodule

// File: rtl/audtx_pack.sv
`timescale 1ns/1ps
module audtx_pack
    import audtx_pkg::*;
(
    input  txcfg_t            cfg,
    input  logic [WORD_W-1:0] wdata,
    output logic [1:0]        cnt,
    output logic [SMP_W-1:0]  s0,
    output logic [SMP_W-1:0]  s1
);
    always_comb begin
        if (cfg.compact) begin
            cnt = 2'd2;
            s0  = pad_half(cfg.size, wdata[HALF_W-1:0]);
            s1  = pad_half(cfg.size, wdata[WORD_W-1:HALF_W]);
        end else begin
            cnt = 2'd1;
            s0  = pad_word(cfg.size, wdata);
            s1  = '0;
        end
    end
endmodule

// File: rtl/audtx_store.sv
`timescale 1ns/1ps
module audtx_store
    import audtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_req,
    input  logic [1:0]               push_cnt,
    input  logic [SMP_W-1:0]         push_s0,
    input  logic [SMP_W-1:0]         push_s1,
    input  logic                     drain_ok,
    input  logic                     cdc_ready,
    output logic                     cdc_valid,
    output logic [SMP_W-1:0]         cdc_left,
    output logic [SMP_W-1:0]         cdc_right,
    output logic [$clog2(DEPTH):0]   level,
    output txflags_t                 flags
);
    localparam int AW   = $clog2(DEPTH);
    localparam int LW   = AW + 1;
    localparam int EW   = LW + 1;
    localparam int HALF = DEPTH / 2;

    logic [SMP_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             draining;
    logic [EW-1:0]    mid, lvl_a, lvl_b;
    logic             push_ok, pop;
    txflags_t         flags_n;

    always_comb begin
        mid       = {1'b0, level} + EW'(push_cnt);
        push_ok   = push_req && (mid <= EW'(DEPTH));
        cdc_valid = drain_ok && (level >= LW'(2))
                    && (draining || level >= LW'(HALF));
        pop       = cdc_valid && cdc_ready;
        lvl_a     = push_ok ? mid : {1'b0, level};
        lvl_b     = pop ? lvl_a - EW'(2) : lvl_a;

        // write effects first, drain effects last
        flags_n = flags;
        if (push_ok) begin
            if (mid != '0) begin
                flags_n.empty = 1'b0;
                flags_n.under = 1'b0;
            end
            if (mid >= EW'(HALF))  flags_n.half = 1'b0;
            if (mid >= EW'(DEPTH)) flags_n.full = 1'b1;
        end
        if (pop) begin
            flags_n.full = 1'b0;
            if (lvl_b <= EW'(HALF)) flags_n.half = 1'b1;
            if (lvl_b == '0) begin
                flags_n.empty = 1'b1;
                flags_n.under = 1'b1;
            end
        end
    end

    assign cdc_left  = mem[rd_ptr];
    assign cdc_right = mem[rd_ptr + AW'(1)];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_s0;
            if (push_cnt == 2'd2) mem[wr_ptr + AW'(1)] <= push_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            draining <= 1'b0;
            flags    <= '{empty: 1'b1, half: 1'b1, full: 1'b0, under: 1'b0};
        end else begin
            level    <= lvl_b[LW-1:0];
            if (push_ok) wr_ptr <= wr_ptr + AW'(push_cnt);
            if (pop)     rd_ptr <= rd_ptr + AW'(2);
            draining <= pop && (lvl_b >= EW'(2));
            flags    <= flags_n;
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R5
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && ({1'b0, level} + EW'(push_cnt) > EW'(DEPTH)) && !(cdc_valid && cdc_ready))
        |=> $stable(level));

    // R6
    full_level_chk: assert property (@(posedge clk) disable iff (rst)
        flags.full == (level == LW'(DEPTH)));

    // R9
    empty_level_chk: assert property (@(posedge clk) disable iff (rst)
        flags.empty == (level == '0));

    // R7
    drain_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cdc_valid) |-> (level >= LW'(HALF) && drain_ok));

    // R8
    pair_avail_chk: assert property (@(posedge clk) disable iff (rst)
        cdc_valid |-> level >= LW'(2));

    // R11
    refuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cdc_valid && !cdc_ready) |=> ($stable(cdc_left) && $stable(cdc_right)));

endmodule

// File: rtl/audtx_fifo.sv
`timescale 1ns/1ps
module audtx_fifo
    import audtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_we,
    input  logic [5:0]             ctl_wdata,
    input  logic                   smp_we,
    input  logic [31:0]            smp_wdata,
    input  logic                   cdc_ready,
    output logic                   cdc_valid,
    output logic [19:0]            cdc_left,
    output logic [19:0]            cdc_right,
    output logic [$clog2(DEPTH):0] fill_level,
    output logic                   st_empty,
    output logic                   st_half,
    output logic                   st_full,
    output logic                   st_underrun
);
    txcfg_t           cfg;
    txflags_t         flags;
    logic [1:0]       p_cnt;
    logic [SMP_W-1:0] p_s0, p_s1;
    logic             drain_ok;

    audtx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .cfg       (cfg)
    );

    audtx_pack u_pack (
        .cfg   (cfg),
        .wdata (smp_wdata),
        .cnt   (p_cnt),
        .s0    (p_s0),
        .s1    (p_s1)
    );

    assign drain_ok = cfg.en && (cfg.slot3 || cfg.slot4);

    audtx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_req  (smp_we),
        .push_cnt  (p_cnt),
        .push_s0   (p_s0),
        .push_s1   (p_s1),
        .drain_ok  (drain_ok),
        .cdc_ready (cdc_ready),
        .cdc_valid (cdc_valid),
        .cdc_left  (cdc_left),
        .cdc_right (cdc_right),
        .level     (fill_level),
        .flags     (flags)
    );

    assign st_empty    = flags.empty;
    assign st_half     = flags.half;
    assign st_full     = flags.full;
    assign st_underrun = flags.under;

endmodule

// File: tb/audtx_fifo_bench.sv
`timescale 1ns/1ps
module audtx_fifo_bench;

    localparam int DEPTH = 8;
    localparam int LVW   = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctl_we = 1'b0;
    logic [5:0]       ctl_wdata = '0;
    logic             smp_we = 1'b0;
    logic [31:0]      smp_wdata = '0;
    logic             cdc_ready = 1'b0;
    logic             cdc_valid;
    logic [19:0]      cdc_left, cdc_right;
    logic [LVW-1:0]   fill_level;
    logic             st_empty, st_half, st_full, st_underrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audtx_fifo #(.DEPTH(DEPTH)) u_audtx_fifo (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .smp_we(smp_we), .smp_wdata(smp_wdata), .cdc_ready(cdc_ready),
        .cdc_valid(cdc_valid), .cdc_left(cdc_left), .cdc_right(cdc_right),
        .fill_level(fill_level), .st_empty(st_empty), .st_half(st_half),
        .st_full(st_full), .st_underrun(st_underrun)
    );

    // pair monitor, sampled mid-cycle
    int          pair_cnt = 0;
    logic [19:0] log_l [64];
    logic [19:0] log_r [64];
    always @(negedge clk) begin
        if (!rst && cdc_valid && cdc_ready) begin
            log_l[pair_cnt % 64] = cdc_left;
            log_r[pair_cnt % 64] = cdc_right;
            pair_cnt = pair_cnt + 1;
        end
    end

    // control word bits: [0] enable, [1] slot3, [2] slot4, [4:3] size, [5] compact
    localparam logic [5:0] C_EN = 6'h01, C_S3 = 6'h02, C_S4 = 6'h04, C_CMP = 6'h20;

    // {ctrl, word, level, first entry, second entry}
    localparam int NV = 8;
    localparam logic [81:0] VEC [NV] = '{
        {6'h00, 32'h0000ABCD, 4'd1, 20'hABCD0, 20'h00000}, // R2 16-bit
        {6'h08, 32'hFFF3FFFF, 4'd1, 20'hFFFFC, 20'h00000}, // R2 18-bit
        {6'h10, 32'hFFF12345, 4'd1, 20'h12345, 20'h00000}, // R2 20-bit
        {6'h18, 32'h12345ABC, 4'd1, 20'hABC00, 20'h00000}, // R2 12-bit
        {6'h20, 32'h1234ABCD, 4'd2, 20'hABCD0, 20'h12340}, // R3 compact 16
        {6'h38, 32'h0FED0123, 4'd2, 20'h12300, 20'hFED00}, // R3 compact 12
        {6'h30, 32'h11112222, 4'd1, 20'h12222, 20'h00000}, // R4 compact at 20
        {6'h28, 32'h00012345, 4'd1, 20'h48D14, 20'h00000}  // R4 compact at 18
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_we = 1'b1;
        ctl_wdata = v;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic wr_smp(input logic [31:0] v);
        smp_we = 1'b1;
        smp_wdata = v;
        step();
        smp_we = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R8: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        #1;
        // R10 reset state
        do_reset();
        chk("R10", "level", 32'(fill_level), 0);
        chk("R10", "empty", 32'(st_empty), 1);
        chk("R10", "half", 32'(st_half), 1);
        chk("R10", "full", 32'(st_full), 0);
        chk("R10", "underrun", 32'(st_underrun), 0);
        chk("R10", "valid", 32'(cdc_valid), 0);

        // R1 R2 R3 R4: vector walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = (i < 4) ? "R2" : (i < 6) ? "R3" : "R4";
            do_reset();
            wr_ctl(VEC[i][81:76]);
            wr_smp(VEC[i][75:44]);
            chk(rq, $sformatf("vec%0d level", i), 32'(fill_level), 32'(VEC[i][43:40]));
            chk(rq, $sformatf("vec%0d first", i), 32'(cdc_left), 32'(VEC[i][39:20]));
            if (VEC[i][43:40] == 4'd2)
                chk(rq, $sformatf("vec%0d second", i), 32'(cdc_right), 32'(VEC[i][19:0]));
        end

        // R6 fill to full, R5 overflow drop, R11 oldest shown
        do_reset();
        wr_ctl(6'h00);
        for (int k = 1; k <= DEPTH; k++) begin
            wr_smp(32'(k));
            chk("R6", $sformatf("empty@%0d", k), 32'(st_empty), 0);
            chk("R6", $sformatf("half@%0d", k), 32'(st_half), (k < DEPTH/2) ? 1 : 0);
            chk("R6", $sformatf("full@%0d", k), 32'(st_full), (k == DEPTH) ? 1 : 0);
        end
        wr_smp(32'h99);
        chk("R5", "overflow level", 32'(fill_level), DEPTH);
        chk("R11", "oldest left", 32'(cdc_left), 32'h10);
        chk("R11", "second right", 32'(cdc_right), 32'h20);

        // R7 enabled but no slot: nothing drains
        cdc_ready = 1'b1;
        wr_ctl(C_EN);
        repeat (3) step();
        chk("R7", "no slot valid", 32'(cdc_valid), 0);
        chk("R7", "no slot level", 32'(fill_level), DEPTH);

        // R8 R9 full drain through slot 3
        base = pair_cnt;
        wr_ctl(C_EN | C_S3);
        repeat (6) step();
        chk("R8", "pairs sent", 32'(pair_cnt - base), 4);
        chk("R11", "first pair left", 32'(log_l[base % 64]), 32'h10);
        chk("R11", "first pair right", 32'(log_r[base % 64]), 32'h20);
        chk("R8", "last pair right", 32'(log_r[(base + 3) % 64]), 32'h80);
        chk("R9", "level", 32'(fill_level), 0);
        chk("R9", "empty", 32'(st_empty), 1);
        chk("R9", "underrun", 32'(st_underrun), 1);
        chk("R9", "half", 32'(st_half), 1);
        chk("R9", "full", 32'(st_full), 0);

        // R6 write clears underrun
        wr_ctl(6'h00);
        wr_smp(32'h5);
        chk("R6", "underrun cleared", 32'(st_underrun), 0);
        chk("R6", "empty cleared", 32'(st_empty), 0);

        // R7 threshold: below half no drain, at half drains to zero
        do_reset();
        cdc_ready = 1'b1;
        wr_ctl(C_EN | C_S3);
        for (int k = 0; k < DEPTH/2 - 1; k++) wr_smp(32'(k + 1));
        step();
        chk("R7", "below half valid", 32'(cdc_valid), 0);
        chk("R7", "below half level", 32'(fill_level), DEPTH/2 - 1);
        wr_smp(32'h4);
        repeat (4) step();
        chk("R8", "drained past half", 32'(fill_level), 0);
        chk("R9", "underrun at zero", 32'(st_underrun), 1);

        // R8 odd level through slot 4 leaves one sample
        do_reset();
        wr_ctl(6'h00);
        for (int k = 0; k < 5; k++) wr_smp(32'(k + 1));
        wr_ctl(C_EN | C_S4);
        repeat (5) step();
        chk("R8", "odd leftover", 32'(fill_level), 1);
        chk("R9", "no underrun", 32'(st_underrun), 0);
        chk("R9", "not empty", 32'(st_empty), 0);
        chk("R9", "half set", 32'(st_half), 1);
        chk("R8", "valid idle", 32'(cdc_valid), 0);
        chk("R11", "leftover sample", 32'(cdc_left), 32'h50);

        // R8 refusal mid-drain ends it below threshold
        do_reset();
        cdc_ready = 1'b0;
        wr_ctl(6'h00);
        for (int k = 0; k < DEPTH/2; k++) wr_smp(32'(k + 1));
        wr_ctl(C_EN | C_S3);
        step();
        chk("R8", "refused level", 32'(fill_level), DEPTH/2);
        chk("R11", "refused left held", 32'(cdc_left), 32'h10);
        cdc_ready = 1'b1;
        step();
        chk("R8", "one pair taken", 32'(fill_level), DEPTH/2 - 2);
        cdc_ready = 1'b0;
        step();
        cdc_ready = 1'b1;
        repeat (3) step();
        chk("R8", "stopped after refusal", 32'(fill_level), DEPTH/2 - 2);
        chk("R8", "valid after refusal", 32'(cdc_valid), 0);

        // R5 compact room: exact fit, then drops
        do_reset();
        cdc_ready = 1'b0;
        wr_ctl(C_CMP);
        for (int k = 0; k < DEPTH/2; k++) wr_smp(32'h00020001 + 32'(k));
        chk("R5", "compact full level", 32'(fill_level), DEPTH);
        chk("R6", "compact full flag", 32'(st_full), 1);
        wr_smp(32'hAAAABBBB);
        chk("R5", "compact drop level", 32'(fill_level), DEPTH);
        chk("R5", "compact drop left", 32'(cdc_left), 32'h00010);

        do_reset();
        wr_ctl(6'h00);
        for (int k = 0; k < DEPTH - 1; k++) wr_smp(32'(k + 1));
        wr_ctl(C_CMP);
        wr_smp(32'h77776666);
        chk("R5", "pair no room level", 32'(fill_level), DEPTH - 1);
        chk("R5", "pair no room full", 32'(st_full), 0);
        chk("R1", "compact applies", 32'(cdc_left), 32'h10);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule